// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block holds the two status flags that tell firmware why the core last came out of reset: a timeout flag (status bit 4) and a power-down flag (status bit 3). It also supplies the values that status bits 1 and 0 take when a reset occurs. Both flags are updated from two things together: which reset source fired, and whether the core was asleep at that moment. A master-clear while awake leaves both flags untouched.

The core's instruction decoder also drives the flags. It sends one-cycle strobes for the clear-watchdog and sleep instructions, and each strobe loads a fixed flag pattern. The watchdog counter, the oscillator stop and the wake-up logic sit outside this block. Only their event signals arrive here.

All state is held in registers clocked by `clk`. Every input is sampled at a rising edge, and its effect is visible on the outputs right after that edge.

Top module: `rst_cause_tracker`

## Requirements
- R1: A cycle with `por_pulse` high sets `flag_timeout`=1, `flag_powerdown`=1, `stat_bit1`=0 and `stat_bit0`=POR_BIT0_VAL (default 0) after that edge.
- R2: A master-clear (`mclr_pulse`, no power-on reset) while `sleep_active`=0 leaves `flag_timeout` and `flag_powerdown` unchanged.
- R3: A master-clear (no power-on reset) while `sleep_active`=1 sets `flag_timeout`=1 and `flag_powerdown`=0.
- R4: A watchdog reset (`wdt_pulse`, no other reset) while `sleep_active`=0 sets `flag_timeout`=0 and `flag_powerdown`=1.
- R5: A watchdog reset (no other reset) while `sleep_active`=1 sets both flags to 0.
- R6: Any applied master-clear or watchdog reset sets `stat_bit1`=1 and `stat_bit0`=1. Cycles with no reset leave both bits unchanged.
- R7: With no reset present, `clrwdt_stb` alone sets both flags to 1.
- R8: With no reset present, `sleep_stb` sets `flag_timeout`=1 and `flag_powerdown`=0. When both strobes are high, the sleep strobe wins (default SLEEP_WINS=1).
- R9: Only one reset applies per cycle, chosen in the order power-on, then master-clear, then watchdog. An applied reset overrides any instruction strobe in the same cycle.
- R10: A cycle with no reset and no strobe leaves all four outputs unchanged, whatever `sleep_active` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on reset event |
| mclr_pulse | input | 1 | External master-clear reset event |
| wdt_pulse | input | 1 | Watchdog timeout reset event |
| sleep_active | input | 1 | High while the core is asleep |
| clrwdt_stb | input | 1 | One-cycle clear-watchdog instruction strobe |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| flag_timeout | output | 1 | Timeout flag (status bit 4) |
| flag_powerdown | output | 1 | Power-down flag (status bit 3) |
| stat_bit1 | output | 1 | Reset-time value for status bit 1 |
| stat_bit0 | output | 1 | Reset-time value for status bit 0 |

## Verification
The bench builds the block with its defaults: POR_BIT0_VAL=0 and SLEEP_WINS=1. With these values the power-on value of bit 0 is known, and the case where both strobes are high follows the sleep-wins order. Random cycles mix coincident resets, strobes and both sleep levels, so every pairing of reset source and sleep state is reached, including ties between sources.

// File: rtl/rct_pkg.sv
package rct_pkg;
   // Reset source after priority selection; larger value = higher priority
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_WDT  = 2'd1,
      SRC_MCLR = 2'd2,
      SRC_POR  = 2'd3
   } rst_src_e;

   typedef struct packed {
      logic timeout;
      logic powerdown;
   } cause_flags_t;

   localparam cause_flags_t FLAGS_BOTH_SET = '{timeout: 1'b1, powerdown: 1'b1};
   localparam cause_flags_t FLAGS_ASLEEP   = '{timeout: 1'b1, powerdown: 1'b0};
   localparam cause_flags_t FLAGS_WDT_RUN  = '{timeout: 1'b0, powerdown: 1'b1};
   localparam cause_flags_t FLAGS_CLEARED  = '{timeout: 1'b0, powerdown: 1'b0};
endpackage

// File: rtl/rct_src_arbiter.sv
module rct_src_arbiter
   import rct_pkg::*;
(
   input  logic     por_i,
   input  logic     mclr_i,
   input  logic     wdt_i,
   output rst_src_e src_o
);
   always_comb begin
      if (por_i)       src_o = SRC_POR;
      else if (mclr_i) src_o = SRC_MCLR;
      else if (wdt_i)  src_o = SRC_WDT;
      else             src_o = SRC_NONE;
   end
endmodule

// File: rtl/rct_flag_next.sv
module rct_flag_next
   import rct_pkg::*;
#(
   parameter int SLEEP_WINS = 1
) (
   input  rst_src_e     src_i,
   input  logic         asleep_i,
   input  logic         clrwdt_i,
   input  logic         sleep_i,
   input  cause_flags_t cur_i,
   output cause_flags_t nxt_o
);
   cause_flags_t strobe_nxt;

   generate
      if (SLEEP_WINS != 0) begin : g_sleep_first
         always_comb begin
            if (sleep_i)       strobe_nxt = FLAGS_ASLEEP;
            else if (clrwdt_i) strobe_nxt = FLAGS_BOTH_SET;
            else               strobe_nxt = cur_i;
         end
      end else begin : g_clrwdt_first
         always_comb begin
            if (clrwdt_i)     strobe_nxt = FLAGS_BOTH_SET;
            else if (sleep_i) strobe_nxt = FLAGS_ASLEEP;
            else              strobe_nxt = cur_i;
         end
      end
   endgenerate

   always_comb begin
      unique case (src_i)
         SRC_POR:  nxt_o = FLAGS_BOTH_SET;
         SRC_MCLR: nxt_o = asleep_i ? FLAGS_ASLEEP  : cur_i;
         SRC_WDT:  nxt_o = asleep_i ? FLAGS_CLEARED : FLAGS_WDT_RUN;
         default:  nxt_o = strobe_nxt;
      endcase
   end
endmodule

// File: rtl/rct_low_bits.sv
module rct_low_bits
   import rct_pkg::*;
#(
   parameter int POR_BIT0_VAL = 0
) (
   input  logic     clk,
   input  rst_src_e src_i,
   output logic     bit1_o,
   output logic     bit0_o
);
   localparam logic POR_B0 = (POR_BIT0_VAL != 0);

   always_ff @(posedge clk) begin
      unique case (src_i)
         SRC_POR: begin
            bit1_o <= 1'b0;
            bit0_o <= POR_B0;
         end
         SRC_MCLR, SRC_WDT: begin
            bit1_o <= 1'b1;
            bit0_o <= 1'b1;
         end
         default: begin
            bit1_o <= bit1_o;
            bit0_o <= bit0_o;
         end
      endcase
   end
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
   import rct_pkg::*;
#(
   parameter int POR_BIT0_VAL = 0,
   parameter int SLEEP_WINS   = 1
) (
   input  logic clk,
   input  logic por_pulse,
   input  logic mclr_pulse,
   input  logic wdt_pulse,
   input  logic sleep_active,
   input  logic clrwdt_stb,
   input  logic sleep_stb,
   output logic flag_timeout,
   output logic flag_powerdown,
   output logic stat_bit1,
   output logic stat_bit0
);
   generate
      if (POR_BIT0_VAL < 0 || POR_BIT0_VAL > 1) begin : g_bad_b0
         $error("POR_BIT0_VAL must be 0 or 1");
      end
      if (SLEEP_WINS < 0 || SLEEP_WINS > 1) begin : g_bad_order
         $error("SLEEP_WINS must be 0 or 1");
      end
   endgenerate

   rst_src_e     src;
   cause_flags_t flags_q;
   cause_flags_t flags_d;

   rct_src_arbiter u_arb (
      .por_i  (por_pulse),
      .mclr_i (mclr_pulse),
      .wdt_i  (wdt_pulse),
      .src_o  (src)
   );

   rct_flag_next #(.SLEEP_WINS(SLEEP_WINS)) u_next (
      .src_i    (src),
      .asleep_i (sleep_active),
      .clrwdt_i (clrwdt_stb),
      .sleep_i  (sleep_stb),
      .cur_i    (flags_q),
      .nxt_o    (flags_d)
   );

   always_ff @(posedge clk) begin
      flags_q <= flags_d;
   end

   rct_low_bits #(.POR_BIT0_VAL(POR_BIT0_VAL)) u_low (
      .clk    (clk),
      .src_i  (src),
      .bit1_o (stat_bit1),
      .bit0_o (stat_bit0)
   );

   assign flag_timeout   = flags_q.timeout;
   assign flag_powerdown = flags_q.powerdown;
endmodule

// File: rtl/rct_checker.sv
module rct_checker (
   input logic clk,
   input logic por_pulse,
   input logic mclr_pulse,
   input logic wdt_pulse,
   input logic sleep_active,
   input logic clrwdt_stb,
   input logic sleep_stb,
   input logic flag_timeout,
   input logic flag_powerdown,
   input logic stat_bit1,
   input logic stat_bit0
);
   // Checks are enabled only after a first power-on reset has been seen
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | por_pulse;

   logic any_rst;
   assign any_rst = por_pulse | mclr_pulse | wdt_pulse;

   p_por_sets_r1: assert property (@(posedge clk) disable iff (!armed)
      por_pulse |=> (flag_timeout && flag_powerdown && !stat_bit1));

   p_mclr_awake_r2: assert property (@(posedge clk) disable iff (!armed)
      (mclr_pulse && !por_pulse && !sleep_active)
         |=> ($stable(flag_timeout) && $stable(flag_powerdown)));

   p_mclr_asleep_r3: assert property (@(posedge clk) disable iff (!armed)
      (mclr_pulse && !por_pulse && sleep_active)
         |=> (flag_timeout && !flag_powerdown));

   p_wdt_awake_r4: assert property (@(posedge clk) disable iff (!armed)
      (wdt_pulse && !mclr_pulse && !por_pulse && !sleep_active)
         |=> (!flag_timeout && flag_powerdown));

   p_wdt_asleep_r5: assert property (@(posedge clk) disable iff (!armed)
      (wdt_pulse && !mclr_pulse && !por_pulse && sleep_active)
         |=> (!flag_timeout && !flag_powerdown));

   p_low_bits_r6: assert property (@(posedge clk) disable iff (!armed)
      ((mclr_pulse || wdt_pulse) && !por_pulse) |=> (stat_bit1 && stat_bit0));

   p_clrwdt_r7: assert property (@(posedge clk) disable iff (!armed)
      (!any_rst && clrwdt_stb && !sleep_stb) |=> (flag_timeout && flag_powerdown));

   p_sleep_r8: assert property (@(posedge clk) disable iff (!armed)
      (!any_rst && sleep_stb) |=> (flag_timeout && !flag_powerdown));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!armed)
      (!any_rst && !clrwdt_stb && !sleep_stb)
         |=> ($stable(flag_timeout) && $stable(flag_powerdown)
              && $stable(stat_bit1) && $stable(stat_bit0)));
endmodule

bind rst_cause_tracker rct_checker u_rct_checker (
   .clk            (clk),
   .por_pulse      (por_pulse),
   .mclr_pulse     (mclr_pulse),
   .wdt_pulse      (wdt_pulse),
   .sleep_active   (sleep_active),
   .clrwdt_stb     (clrwdt_stb),
   .sleep_stb      (sleep_stb),
   .flag_timeout   (flag_timeout),
   .flag_powerdown (flag_powerdown),
   .stat_bit1      (stat_bit1),
   .stat_bit0      (stat_bit0)
);

// File: tb/rst_cause_tracker_test.sv
module rst_cause_tracker_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_pulse = 1'b0, mclr_pulse = 1'b0, wdt_pulse = 1'b0;
   logic sleep_active = 1'b0, clrwdt_stb = 1'b0, sleep_stb = 1'b0;
   logic flag_timeout, flag_powerdown, stat_bit1, stat_bit0;

   int n_cmp = 0;
   int n_bad = 0;
   logic [3:0] exp_q;   // {timeout, powerdown, bit1, bit0}
   string      exp_tag;

   rst_cause_tracker uut (
      .clk(clk), .por_pulse(por_pulse), .mclr_pulse(mclr_pulse),
      .wdt_pulse(wdt_pulse), .sleep_active(sleep_active),
      .clrwdt_stb(clrwdt_stb), .sleep_stb(sleep_stb),
      .flag_timeout(flag_timeout), .flag_powerdown(flag_powerdown),
      .stat_bit1(stat_bit1), .stat_bit0(stat_bit0)
   );

   // Expected next state from the requirements
   function automatic logic [3:0] model_next(logic [3:0] cur, logic p, logic m,
                                             logic w, logic s, logic c, logic z);
      logic [3:0] n;
      n = cur;
      if (p)      n = 4'b1100;                           // R1, R9
      else if (m) begin
         n[1:0] = 2'b11;                                 // R6
         if (s) n[3:2] = 2'b10;                          // R3
      end
      else if (w) begin
         n[1:0] = 2'b11;                                 // R6
         n[3:2] = s ? 2'b00 : 2'b01;                     // R4, R5
      end
      else if (z) n[3:2] = 2'b10;                        // R8
      else if (c) n[3:2] = 2'b11;                        // R7
      return n;                                          // R10 otherwise
   endfunction

   function automatic string model_tag(logic p, logic m, logic w, logic s,
                                       logic c, logic z);
      if (p)      return (m || w || c || z) ? "R9" : "R1";
      if (m)      return (w || c || z) ? "R9" : (s ? "R3" : "R2");
      if (w)      return (c || z) ? "R9" : (s ? "R5" : "R4");
      if (z)      return "R8";
      if (c)      return "R7";
      return "R10";
   endfunction

   task automatic compare();
      logic [3:0] act;
      act = {flag_timeout, flag_powerdown, stat_bit1, stat_bit0};
      n_cmp++;
      if (act !== exp_q) begin
         n_bad++;
         $display("FAIL %s: outputs {to,pd,b1,b0} = %b expected %b", exp_tag, act, exp_q);
      end
      // R6 named separately: low bits after any applied master-clear/watchdog
   endtask

   // Drive one cycle at negedge, then check just before the following negedge
   task automatic step(logic p, logic m, logic w, logic s, logic c, logic z);
      por_pulse = p; mclr_pulse = m; wdt_pulse = w;
      sleep_active = s; clrwdt_stb = c; sleep_stb = z;
      exp_q   = model_next(exp_q, p, m, w, s, c, z);
      exp_tag = model_tag(p, m, w, s, c, z);
      @(posedge clk);
      #2;
      compare();
      @(negedge clk);
   endtask

   initial begin
      exp_q = 4'b0000;
      @(negedge clk);
      // Reset state (R1)
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 1, 0, 0);
      // Directed cases
      step(0, 0, 1, 0, 0, 0);   // R4
      step(0, 1, 0, 0, 0, 0);   // R2: flags stay 0,1; R6 bits set
      step(0, 0, 0, 0, 1, 0);   // R7
      step(0, 0, 1, 1, 0, 0);   // R5
      step(0, 1, 0, 0, 0, 0);   // R2 holds 0,0
      step(0, 1, 0, 1, 0, 0);   // R3
      step(0, 0, 0, 0, 1, 1);   // R8 both strobes, sleep wins
      step(0, 0, 0, 1, 0, 0);   // R10 idle while asleep
      step(1, 1, 1, 1, 1, 1);   // R9 POR wins everything
      step(0, 1, 1, 1, 0, 0);   // R9 master-clear over watchdog -> 1,0
      step(0, 0, 1, 0, 0, 1);   // R9 watchdog over sleep strobe
      step(0, 0, 0, 0, 0, 0);   // R10
      // Random mix with fixed seed
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
              $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #500000;
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule